// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block executes four 32-bit data-processing operations (add, bitwise test, move and compare) against a sixteen-entry register file of 32-bit words. It also maintains a four-bit condition flag register that holds negative, zero, carry and overflow. The block accepts one instruction word per clock when the valid strobe is high. It decodes the register indices from the word and forms the second operand. That operand is either a rotated 8-bit immediate or a pre-shifted value supplied by an external shifter, together with that shifter's carry-out. The block then computes the result, writes it back when the operation produces one, and updates the flags under opcode-specific rules.

Encodings the block does not support raise a one-cycle illegal-instruction pulse. A register-form instruction that asks for flags while targeting register 15 raises the same pulse. In both cases the register file and the flags are left untouched. A combinational read port exposes any register, so the surrounding pipeline or a bench can observe the architectural state.

Top module: `dp_exec_unit`

## Requirements
- R1: Instruction fields: bit 25 selects immediate form, bits [24:21] are the operation code, bit 20 is the set-flags bit, bits [19:16] index the first operand register and bits [15:12] index the destination. Add (opcode 0x4) writes first operand plus second operand to the destination.
- R2: In immediate form the second operand is instruction bits [7:0], zero-extended and rotated right by twice the value in bits [11:8].
- R3: Add with set-flags 1 and destination not 15 sets N to result bit 31, Z when the result is zero, C to the unsigned carry-out and V to signed overflow. Add with set-flags 0 leaves all flags unchanged.
- R4: Test (opcode 0x8) forms the bitwise AND of the two operands and writes no register. It always updates N and Z, always takes C from the operand carry (R10), and leaves V unchanged.
- R5: Move (opcode 0xD) writes the second operand to the destination. With set-flags 1 and destination not 15, it sets N and Z from that value and C from the operand carry. V is never changed by move.
- R6: Compare (opcode 0xA) computes first minus second operand and writes no register. It always sets N and Z from the difference, sets C to 1 when the second operand is unsigned less than or equal to the first, and sets V on signed overflow of the subtraction.
- R7: For add and move, a destination of 15 suppresses every flag update while the register write still happens.
- R8: A register-form instruction (bit 25 = 0) with set-flags 1 and destination 15 is illegal. It raises the illegal output and changes no register and no flag.
- R9: Any operation code other than 0x4, 0x8, 0xA and 0xD raises the illegal output for exactly one cycle and changes no register and no flag.
- R10: Operand carry: in register form it is the shifter carry input. In immediate form with a nonzero rotate field it is bit 31 of the rotated immediate. In immediate form with a zero rotate field, C keeps its current value.
- R11: Register writes, flag updates and the illegal pulse take effect on the clock edge after a valid instruction. An instruction presented with valid low has no effect.
- R12: A synchronous reset clears all sixteen registers, all four flags and the illegal output.
- R13: The read port returns the register selected by the read address combinationally. The flag output is ordered {N, Z, C, V} from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word valid this cycle |
| instrWord | input | 32 | Data-processing instruction word |
| shiftValue | input | 32 | Pre-shifted second operand for register form |
| shiftCarry | input | 1 | Shifter carry-out for register form |
| rdAddr | input | 4 | Read port register index |
| rdData | output | 32 | Read port data |
| flagsOut | output | 4 | Condition flags {N, Z, C, V} |
| illegalPulse | output | 1 | One-cycle illegal-instruction indication |

## Verification
The main stimulus is a chained instruction sequence, so later entries read registers loaded by earlier ones. Each operation is run in both immediate and register form and with set-flags on and off. Operand pairs are chosen to tell the flag rules apart: a sum that wraps to zero with both carry and overflow, a positive-plus-positive overflow without carry, and compares of equal, smaller and larger operands, including the negative-minus-one overflow case. The immediate cases split a zero rotate, which keeps C, from a nonzero rotate, which takes the rotated top bit. Writes to register 15 with and without set-flags separate the flag-suppression rule from the illegal form, and an unsupported opcode and a low valid strobe confirm that the state is left alone.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam int DATA_W  = 32;
  localparam int REG_CNT = 16;
  localparam int ADDR_W  = $clog2(REG_CNT);
  localparam int OP_W    = 4;
  localparam int FLAG_W  = 4;

  // Flag positions inside the flag vector
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  // Operation codes
  localparam logic [OP_W-1:0] OP_ADD = 4'h4;
  localparam logic [OP_W-1:0] OP_TST = 4'h8;
  localparam logic [OP_W-1:0] OP_CMP = 4'hA;
  localparam logic [OP_W-1:0] OP_MOV = 4'hD;

  // Instruction bit positions
  localparam int BIT_IMM  = 25;
  localparam int OP_LSB   = 21;
  localparam int BIT_SETF = 20;
  localparam int RN_LSB   = 16;
  localparam int RD_LSB   = 12;
  localparam int ROT_LSB  = 8;
  localparam int ROT_W    = 4;
  localparam int IMM_W    = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic            wrEn;
    logic            nzEn;
    logic            cEn;
    logic            vEn;
    logic            illegal;
    logic [OP_W-1:0] op;
  } ctrlStrobe_t;

endpackage

// File: rtl/dpx_ctrl.sv
module dpx_ctrl
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] rdIdx,
  output logic [ADDR_W-1:0] rnIdx
);

  logic            isImm;
  logic            setFlags;
  logic [OP_W-1:0] opCode;
  logic [ROT_W-1:0] rotField;
  logic            destIsTop;
  logic            opKnown;
  logic            badForm;
  logic            carryFromOperand;
  logic            flagsAllowed;

  assign isImm     = instrWord[BIT_IMM];
  assign setFlags  = instrWord[BIT_SETF];
  assign opCode    = instrWord[OP_LSB +: OP_W];
  assign rotField  = instrWord[ROT_LSB +: ROT_W];
  assign rdIdx     = instrWord[RD_LSB +: ADDR_W];
  assign rnIdx     = instrWord[RN_LSB +: ADDR_W];
  assign destIsTop = (rdIdx == ADDR_W'(REG_CNT - 1));

  assign opKnown = (opCode == OP_ADD) || (opCode == OP_TST) ||
                   (opCode == OP_CMP) || (opCode == OP_MOV);
  assign badForm = !isImm && setFlags && destIsTop;

  // Immediate with zero rotate yields no carry: keep C
  assign carryFromOperand = !isImm || (rotField != '0);
  assign flagsAllowed     = setFlags && !destIsTop;

  always_comb begin
    strobe    = '0;
    strobe.op = opCode;
    if (instrValid) begin
      if (!opKnown || badForm) begin
        strobe.illegal = 1'b1;
      end else begin
        unique case (opCode)
          OP_ADD: begin
            strobe.wrEn = 1'b1;
            strobe.nzEn = flagsAllowed;
            strobe.cEn  = flagsAllowed;
            strobe.vEn  = flagsAllowed;
          end
          OP_TST: begin
            strobe.nzEn = 1'b1;
            strobe.cEn  = carryFromOperand;
          end
          OP_MOV: begin
            strobe.wrEn = 1'b1;
            strobe.nzEn = flagsAllowed;
            strobe.cEn  = flagsAllowed && carryFromOperand;
          end
          OP_CMP: begin
            strobe.nzEn = 1'b1;
            strobe.cEn  = 1'b1;
            strobe.vEn  = 1'b1;
          end
          default: strobe.illegal = 1'b1;
        endcase
      end
    end
  end

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.illegal |-> !(strobe.wrEn || strobe.nzEn || strobe.cEn || strobe.vEn));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !instrValid |-> (strobe.wrEn == 1'b0 && strobe.illegal == 1'b0));

endmodule

// File: rtl/dpx_path.sv
module dpx_path
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [ADDR_W-1:0] rdIdx,
  input  logic [ADDR_W-1:0] rnIdx,
  input  logic [DATA_W-1:0] shiftValue,
  input  logic              shiftCarry,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              illegalPulse
);

  localparam int ROT_SH_W = ROT_W + 1;

  logic [DATA_W-1:0]   regFile [REG_CNT];
  logic [FLAG_W-1:0]   flagReg;
  logic                illReg;

  logic [DATA_W-1:0]   opA;
  logic [DATA_W-1:0]   opB;
  logic                opCarry;
  logic [DATA_W-1:0]   immBase;
  logic [ROT_SH_W-1:0] rotAmt;
  logic [2*DATA_W-1:0] immPair;
  logic [DATA_W-1:0]   immVal;

  logic [DATA_W:0]     sumWide;
  logic [DATA_W-1:0]   sumVal;
  logic [DATA_W-1:0]   diffVal;
  logic [DATA_W-1:0]   andVal;
  logic [DATA_W-1:0]   resVal;
  logic                addOvf;
  logic                subOvf;
  logic                nextC;
  logic                nextV;

  // Operand formation
  assign opA     = regFile[rnIdx];
  assign immBase = {{(DATA_W-IMM_W){1'b0}}, instrWord[IMM_W-1:0]};
  assign rotAmt  = {instrWord[ROT_LSB +: ROT_W], 1'b0};
  assign immPair = {immBase, immBase} >> rotAmt;
  assign immVal  = immPair[DATA_W-1:0];
  assign opB     = instrWord[BIT_IMM] ? immVal : shiftValue;
  assign opCarry = instrWord[BIT_IMM] ? immVal[DATA_W-1] : shiftCarry;

  // Arithmetic and logic
  assign sumWide = {1'b0, opA} + {1'b0, opB};
  assign sumVal  = sumWide[DATA_W-1:0];
  assign diffVal = opA - opB;
  assign andVal  = opA & opB;
  assign addOvf  = ((opA ^ sumVal) & (opB ^ sumVal)) >> (DATA_W-1) != '0;
  assign subOvf  = ((opA ^ diffVal) & (~opB ^ diffVal)) >> (DATA_W-1) != '0;

  always_comb begin
    unique case (strobe.op)
      OP_ADD:  resVal = sumVal;
      OP_CMP:  resVal = diffVal;
      OP_TST:  resVal = andVal;
      default: resVal = opB;
    endcase
  end

  always_comb begin
    unique case (strobe.op)
      OP_ADD:  begin nextC = sumWide[DATA_W]; nextV = addOvf; end
      OP_CMP:  begin nextC = (opB <= opA);    nextV = subOvf; end
      default: begin nextC = opCarry;         nextV = flagReg[FLAG_V]; end
    endcase
  end

  // Register file: one write-enabled word per entry
  for (genvar gi = 0; gi < REG_CNT; gi++) begin : g_reg
    logic hit;
    assign hit = strobe.wrEn && (rdIdx == ADDR_W'(gi));
    always_ff @(posedge clk) begin
      if (rst) begin
        regFile[gi] <= '0;
      end else if (hit) begin
        regFile[gi] <= resVal;
      end
    end
  end

  // Flags and illegal pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      flagReg <= '0;
      illReg  <= 1'b0;
    end else begin
      illReg <= strobe.illegal;
      if (strobe.nzEn) begin
        flagReg[FLAG_N] <= resVal[DATA_W-1];
        flagReg[FLAG_Z] <= (resVal == '0);
      end
      if (strobe.cEn) flagReg[FLAG_C] <= nextC;
      if (strobe.vEn) flagReg[FLAG_V] <= nextV;
    end
  end

  assign rdData       = regFile[rdAddr];
  assign flagsOut     = flagReg;
  assign illegalPulse = illReg;

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobe.nzEn || strobe.cEn || strobe.vEn) |=> $stable(flagReg));

  // R5
  mov_v_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.op == OP_MOV) |=> $stable(flagReg[FLAG_V]));

  // R6
  cmp_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.cEn && strobe.op == OP_CMP) |=>
      (flagReg[FLAG_C] == ($past(opB) <= $past(opA))));

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    illegalPulse |-> (flagReg == $past(flagReg)));

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (illegalPulse && !strobe.illegal) |=> !illegalPulse);

endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] shiftValue,
  input  logic              shiftCarry,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              illegalPulse
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] rdIdx;
  logic [ADDR_W-1:0] rnIdx;

  dpx_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobe     (strobe),
    .rdIdx      (rdIdx),
    .rnIdx      (rnIdx)
  );

  dpx_path u_path (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .instrWord    (instrWord),
    .rdIdx        (rdIdx),
    .rnIdx        (rnIdx),
    .shiftValue   (shiftValue),
    .shiftCarry   (shiftCarry),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .flagsOut     (flagsOut),
    .illegalPulse (illegalPulse)
  );

endmodule

// File: tb/dp_exec_unit_tb.sv
`timescale 1ns/1ps
module dp_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] shiftValue = '0;
  logic        shiftCarry = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [3:0]  flagsOut;
  logic        illegalPulse;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 1'b0;

  always #10 clk = ~clk;

  dp_exec_unit u_dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .shiftValue(shiftValue), .shiftCarry(shiftCarry), .rdAddr(rdAddr),
    .rdData(rdData), .flagsOut(flagsOut), .illegalPulse(illegalPulse)
  );

  typedef struct packed {
    logic        imm;
    logic [3:0]  op;
    logic        setF;
    logic [3:0]  rn;
    logic [3:0]  rd;
    logic [11:0] op2;
    logic [31:0] shv;
    logic        shc;
    logic [3:0]  chkReg;
    logic [31:0] expReg;
    logic [3:0]  expFlags;
    logic        expIll;
  } vec_t;

  localparam int NV = 18;
  // Flags are {N,Z,C,V}
  localparam vec_t VECS [NV] = '{
    // R5 R2 R10: mov imm, rotate 0 keeps C
    '{1'b1, 4'hD, 1'b1, 4'h0, 4'h1, 12'h0FF, 32'h0, 1'b0, 4'h1, 32'h000000FF, 4'b0000, 1'b0},
    // R2 R10: rotate field 1 -> 0x80000000, C from bit 31
    '{1'b1, 4'hD, 1'b1, 4'h0, 4'h2, 12'h102, 32'h0, 1'b0, 4'h2, 32'h80000000, 4'b1010, 1'b0},
    // R1 R3: add wraps to zero with carry and overflow
    '{1'b1, 4'h4, 1'b1, 4'h2, 4'h3, 12'h102, 32'h0, 1'b0, 4'h3, 32'h00000000, 4'b0111, 1'b0},
    // R3: add without set-flags keeps flags
    '{1'b1, 4'h4, 1'b0, 4'h1, 4'h4, 12'h001, 32'h0, 1'b0, 4'h4, 32'h00000100, 4'b0111, 1'b0},
    // R6: compare equal, no writeback to r9
    '{1'b1, 4'hA, 1'b1, 4'h1, 4'h9, 12'h0FF, 32'h0, 1'b0, 4'h9, 32'h00000000, 4'b0110, 1'b0},
    // R6 R2: compare smaller minus larger (rotate 12 -> 0x100)
    '{1'b1, 4'hA, 1'b1, 4'h1, 4'h0, 12'hC01, 32'h0, 1'b0, 4'h1, 32'h000000FF, 4'b1000, 1'b0},
    // R4 R10: test register form, set-flags 0, C from shifter
    '{1'b0, 4'h8, 1'b0, 4'h2, 4'h0, 12'h000, 32'h80000000, 1'b1, 4'h0, 32'h00000000, 4'b1010, 1'b0},
    // R4: test giving zero
    '{1'b0, 4'h8, 1'b1, 4'h1, 4'h0, 12'h000, 32'h00000100, 1'b0, 4'h0, 32'h00000000, 4'b0100, 1'b0},
    // R5 R10: mov register form, V kept
    '{1'b0, 4'hD, 1'b1, 4'h0, 4'h5, 12'h000, 32'h7FFFFFFF, 1'b1, 4'h5, 32'h7FFFFFFF, 4'b0010, 1'b0},
    // R3: positive overflow, no carry
    '{1'b0, 4'h4, 1'b1, 4'h5, 4'h6, 12'h000, 32'h00000001, 1'b0, 4'h6, 32'h80000000, 4'b1001, 1'b0},
    // R5: mov without set-flags keeps flags
    '{1'b0, 4'hD, 1'b0, 4'h0, 4'h7, 12'h000, 32'h12345678, 1'b1, 4'h7, 32'h12345678, 4'b1001, 1'b0},
    // R6: compare with set-flags 0 still updates, signed overflow
    '{1'b0, 4'hA, 1'b0, 4'h6, 4'h0, 12'h000, 32'h00000001, 1'b0, 4'h0, 32'h00000000, 4'b0011, 1'b0},
    // R7: mov imm to r15 with set-flags, flags kept
    '{1'b1, 4'hD, 1'b1, 4'h0, 4'hF, 12'h033, 32'h0, 1'b0, 4'hF, 32'h00000033, 4'b0011, 1'b0},
    // R7: add imm to r15 with set-flags, flags kept
    '{1'b1, 4'h4, 1'b1, 4'h1, 4'hF, 12'h001, 32'h0, 1'b0, 4'hF, 32'h00000100, 4'b0011, 1'b0},
    // R8: register form, set-flags, r15 -> illegal
    '{1'b0, 4'hD, 1'b1, 4'h0, 4'hF, 12'h000, 32'h0000DEAD, 1'b0, 4'hF, 32'h00000100, 4'b0011, 1'b1},
    // R9: unsupported opcode 0x0
    '{1'b1, 4'h0, 1'b1, 4'h1, 4'h1, 12'h000, 32'h0, 1'b0, 4'h1, 32'h000000FF, 4'b0011, 1'b1},
    // R10 R4: test imm rotate 0 keeps C and V
    '{1'b1, 4'h8, 1'b0, 4'h1, 4'h0, 12'h00F, 32'h0, 1'b0, 4'h0, 32'h00000000, 4'b0011, 1'b0},
    // R10 R4: test imm rotate 1 -> 0x40000000, C cleared
    '{1'b1, 4'h8, 1'b0, 4'h2, 4'h0, 12'h101, 32'h0, 1'b0, 4'h0, 32'h00000000, 4'b0101, 1'b0}
  };

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] word, input logic [31:0] shv, input logic shc,
                       input logic vld);
    @(negedge clk);
    instrWord  = word;
    shiftValue = shv;
    shiftCarry = shc;
    instrValid = vld;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  function automatic logic [31:0] enc(input logic imm, input logic [3:0] op, input logic s,
                                      input logic [3:0] rn, input logic [3:0] rd,
                                      input logic [11:0] op2);
    return {4'hE, 2'b00, imm, op, s, rn, rd, op2};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      failCnt++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    #1;
    check32("R12 reset flags", 32'(flagsOut), 32'h0);
    check32("R12 reset illegal", 32'(illegalPulse), 32'h0);
    for (int i = 0; i < 16; i++) begin
      rdAddr = 4'(i);
      #1;
      check32("R12 reset reg", rdData, 32'h0);
    end

    // Vector table walk
    for (int k = 0; k < NV; k++) begin
      issue(enc(VECS[k].imm, VECS[k].op, VECS[k].setF, VECS[k].rn, VECS[k].rd, VECS[k].op2),
            VECS[k].shv, VECS[k].shc, 1'b1);
      rdAddr = VECS[k].chkReg;
      #1;
      $display("vector %0d", k);
      check32("R1 vector reg", rdData, VECS[k].expReg);
      check32("R3 vector flags", 32'(flagsOut), 32'(VECS[k].expFlags));
      check32("R9 vector illegal", 32'(illegalPulse), 32'(VECS[k].expIll));
    end

    // R9: pulse lasts exactly one cycle
    issue(enc(1'b1, 4'h3, 1'b0, 4'h0, 4'h2, 12'h001), 32'h0, 1'b0, 1'b1);
    #1;
    check32("R9 pulse high", 32'(illegalPulse), 32'h1);
    @(negedge clk);
    #1;
    check32("R9 pulse one cycle", 32'(illegalPulse), 32'h0);
    rdAddr = 4'h2;
    #1;
    check32("R9 reg untouched", rdData, 32'h80000000);

    // R11: valid low has no effect
    issue(enc(1'b1, 4'h4, 1'b1, 4'h0, 4'h8, 12'h055), 32'h0, 1'b0, 1'b0);
    rdAddr = 4'h8;
    #1;
    check32("R11 no valid reg", rdData, 32'h0);
    check32("R11 no valid flags", 32'(flagsOut), 32'h5);

    // R13: read port is combinational
    rdAddr = 4'h1;
    #1;
    check32("R13 read r1", rdData, 32'h000000FF);
    rdAddr = 4'h5;
    #1;
    check32("R13 read r5", rdData, 32'h7FFFFFFF);

    // R12: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rdAddr = 4'h1;
    #1;
    check32("R12 mid reset reg", rdData, 32'h0);
    check32("R12 mid reset flags", 32'(flagsOut), 32'h0);

    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule